// File: doc/BRIEF.md
# Dual-Channel Sample Formatter with DDR Output

This block sits after two 12-bit converter channels, A and B, and prepares their results for one shared output bus. Each incoming sample arrives in offset binary with an over-range flag. The block recodes the sample into offset binary, two's complement or Gray code. It then sends both channels over one 12-bit bus plus one over-range bit, at double data rate.

`clk` is the internal double-rate clock. The block derives an output clock `clk_out` at half that rate. Once per `clk_out` period, both channels are captured together on the rising `clk` edge at which `clk_out` falls. Channel A is driven for the low phase that follows, and channel B for the high phase after it.

The output format comes from a three-level board pin unless a three-bit override field selects it. An active-low reset parks the output clock low and forces the over-range bit high. The over-range bit stays high until the calibration-done input is seen.

Top module: `adc_ddr_formatter`

## Requirements
- R1: Offset-binary format passes the 12-bit sample through unchanged (0x800 gives 0x800, 0xFFF gives 0xFFF). Override code 3'b100 selects it.
- R2: Two's-complement format inverts bit 11 and keeps bits 10:0 (0x000 gives 0x800, 0xFFF gives 0x7FF). Override code 3'b001 selects it.
- R3: Gray format keeps bit 11, and each lower bit i is sample[i] XOR sample[i+1] (0x800 gives 0xC00, 0xFFF gives 0x800). Override code 3'b010 selects it.
- R4: With override 3'b000, `fmt_pin` selects the format: 2'b00 (low) gives offset binary, 2'b01 (floating) gives two's complement, 2'b10 (high) gives Gray, and 2'b11 is treated as floating.
- R5: Any reserved override code (3'b011, 3'b101, 3'b110, 3'b111) falls back to pin control, exactly as 3'b000 does.
- R6: After reset, `clk_out` toggles on every `clk` edge. Both channels are captured on an edge at which `clk_out` goes from 1 to 0. The formatted channel A word is on `dout` for the following low phase, and channel B for the following high phase.
- R7: While `rst_n` is low, `clk_out` is 0 and `dout` is 0. The first `clk` edge after release drives `clk_out` high.
- R8: `or_out` is 1 during reset and stays 1 until `cal_done` is sampled high. From then on, it carries the channel A flag in the low phase and the channel B flag in the high phase.
- R9: The format is sampled at the capture edge, so both words of one sample instant use the same format even if the select changes before channel B is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_done | input | 1 | Calibration finished; releases the over-range hold |
| fmt_pin | input | 2 | Three-level format pin: 00 low, 01 floating, 10 high |
| fmt_ovr | input | 3 | Format override code |
| a_data | input | 12 | Channel A sample, offset binary |
| a_ovr | input | 1 | Channel A over-range flag |
| b_data | input | 12 | Channel B sample, offset binary |
| b_ovr | input | 1 | Channel B over-range flag |
| clk_out | output | 1 | Generated output clock, half the `clk` rate |
| dout | output | 12 | DDR data bus: A while `clk_out` is low, B while it is high |
| or_out | output | 1 | DDR over-range bit |

## Verification
The assertions assume that the sample inputs and `fmt_ovr` are stable around each capture edge. The format assertions compare `dout` with the inputs and override code as they stood one or two edges earlier. They therefore rely on those values being the ones the capture edge saw. The stimulus changes every input only on falling `clk` edges, and only when `clk_out` is high, so each value is held across the next capture edge. The one exception is the R9 test, which changes the override code during the low phase on purpose. That change comes after the capture edge and has no effect until the next capture.

// File: rtl/adc_ddr_formatter.sv
module adc_ddr_formatter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cal_done,
  input  logic [1:0]   fmt_pin,
  input  logic [2:0]   fmt_ovr,
  input  logic [W-1:0] a_data,
  input  logic         a_ovr,
  input  logic [W-1:0] b_data,
  input  logic         b_ovr,
  output logic         clk_out,
  output logic [W-1:0] dout,
  output logic         or_out
);

  localparam logic [1:0] F_OFFS = 2'd0;
  localparam logic [1:0] F_TWOS = 2'd1;
  localparam logic [1:0] F_GRAY = 2'd2;

  logic         ph;
  logic         cal_wait;
  logic         cal_blk;
  logic [1:0]   sel;
  logic [W-1:0] b_hold;
  logic         b_or;

  function automatic logic [W-1:0] recode(input logic [W-1:0] x, input logic [1:0] f);
    case (f)
      F_TWOS:  recode = {~x[W-1], x[W-2:0]};
      F_GRAY:  recode = x ^ (x >> 1);
      default: recode = x;
    endcase
  endfunction

  always_comb begin
    case (fmt_ovr)
      3'b001:  sel = F_TWOS;
      3'b010:  sel = F_GRAY;
      3'b100:  sel = F_OFFS;
      default:
        case (fmt_pin)
          2'b00:   sel = F_OFFS;
          2'b10:   sel = F_GRAY;
          default: sel = F_TWOS;
        endcase
    endcase
  end

  assign cal_blk = cal_wait & ~cal_done;
  assign clk_out = ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= 1'b0;
      cal_wait <= 1'b1;
      dout     <= '0;
      or_out   <= 1'b1;
      b_hold   <= '0;
      b_or     <= 1'b1;
    end else begin
      ph <= ~ph;
      if (cal_done) cal_wait <= 1'b0;
      if (ph) begin
        dout   <= recode(a_data, sel);
        or_out <= cal_blk | a_ovr;
        b_hold <= recode(b_data, sel);
        b_or   <= cal_blk | b_ovr;
      end else begin
        dout   <= b_hold;
        or_out <= cal_blk | b_or;
      end
    end
  end

  assert_clk_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> clk_out != $past(clk_out));

  assert_or_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_wait |-> or_out);

  assert_twos_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_out && $past(rst_n) && $past(fmt_ovr) == 3'b001)
      |-> dout == {~$past(a_data[W-1]), $past(a_data[W-2:0])});

  assert_gray_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_out && $past(rst_n) && $past(fmt_ovr) == 3'b010)
      |-> (dout[W-1] == $past(a_data[W-1]) &&
           dout[W-2] == ($past(a_data[W-1]) ^ $past(a_data[W-2]))));

  assert_offs_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_out && $past(rst_n, 2) && $past(fmt_ovr, 2) == 3'b100)
      |-> dout == $past(b_data, 2));

endmodule

// File: tb/adc_ddr_formatter_test.sv
module adc_ddr_formatter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        cal_done = 1'b0;
  logic [1:0]  fmt_pin = 2'b00;
  logic [2:0]  fmt_ovr = 3'b000;
  logic [11:0] a_data = '0, b_data = '0;
  logic        a_ovr = 1'b0, b_ovr = 1'b0;
  logic        clk_out, or_out;
  logic [11:0] dout;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  adc_ddr_formatter uut (
    .clk(clk), .rst_n(rst_n), .cal_done(cal_done), .fmt_pin(fmt_pin), .fmt_ovr(fmt_ovr),
    .a_data(a_data), .a_ovr(a_ovr), .b_data(b_data), .b_ovr(b_ovr),
    .clk_out(clk_out), .dout(dout), .or_out(or_out)
  );

  // {a, b, a_ovr, b_ovr, pin, ovr, expected A, expected B}
  localparam logic [54:0] VEC [12] = '{
    {12'h800, 12'hFFF, 1'b0, 1'b1, 2'b00, 3'b000, 12'h800, 12'hFFF},
    {12'h000, 12'h001, 1'b1, 1'b0, 2'b01, 3'b000, 12'h800, 12'h801},
    {12'h800, 12'hFFF, 1'b0, 1'b0, 2'b10, 3'b000, 12'hC00, 12'h800},
    {12'hFFE, 12'h001, 1'b1, 1'b1, 2'b11, 3'b000, 12'h7FE, 12'h801},
    {12'hFFF, 12'h800, 1'b0, 1'b1, 2'b00, 3'b001, 12'h7FF, 12'h000},
    {12'h001, 12'hFFE, 1'b1, 1'b0, 2'b00, 3'b010, 12'h001, 12'h801},
    {12'hABC, 12'h123, 1'b0, 1'b0, 2'b10, 3'b100, 12'hABC, 12'h123},
    {12'h0F0, 12'h5A5, 1'b0, 1'b1, 2'b10, 3'b011, 12'h088, 12'h777},
    {12'h3C3, 12'hC3C, 1'b1, 1'b0, 2'b00, 3'b111, 12'h3C3, 12'hC3C},
    {12'h400, 12'hBFF, 1'b0, 1'b0, 2'b01, 3'b101, 12'hC00, 12'h3FF},
    {12'hFFF, 12'h000, 1'b1, 1'b1, 2'b10, 3'b110, 12'h800, 12'h000},
    {12'h555, 12'hAAA, 1'b0, 1'b0, 2'b01, 3'b010, 12'h7FF, 12'hFFF}
  };

  task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] pin, input logic [2:0] ovr);
    if (ovr == 3'b000) return "R4";
    if (ovr == 3'b001) return "R2";
    if (ovr == 3'b010) return "R3";
    if (ovr == 3'b100) return "R1";
    return (pin == 2'b00) ? "R5 (pin low)" : "R5";
  endfunction

  task automatic run_pair(input logic [11:0] a, input logic [11:0] b, input logic ao, input logic bo,
                          input logic [1:0] pin, input logic [2:0] ovr,
                          input logic [11:0] ea, input logic [11:0] eb,
                          input logic eao, input logic ebo, input string tag);
    while (clk_out !== 1'b1) @(negedge clk);
    a_data = a; b_data = b; a_ovr = ao; b_ovr = bo; fmt_pin = pin; fmt_ovr = ovr;
    @(negedge clk);
    chk({11'd0, clk_out}, 12'd0, {tag, " R6 A phase clk_out"});
    chk(dout, ea, {tag, " R6 channel A data"});
    chk({11'd0, or_out}, {11'd0, eao}, {tag, " R8 A over-range"});
    @(negedge clk);
    chk({11'd0, clk_out}, 12'd1, {tag, " R6 B phase clk_out"});
    chk(dout, eb, {tag, " R6 channel B data"});
    chk({11'd0, or_out}, {11'd0, ebo}, {tag, " R8 B over-range"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({11'd0, clk_out}, 12'd0, "R7 clk_out in reset");
    chk(dout, 12'h000, "R7 dout in reset");
    chk({11'd0, or_out}, 12'd1, "R8 or_out in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk({11'd0, clk_out}, 12'd1, "R7 clk_out after first edge");
    // calibration pending: over-range held
    run_pair(12'h123, 12'h456, 1'b0, 1'b0, 2'b00, 3'b100, 12'h123, 12'h456, 1'b1, 1'b1, "R8 cal pending");
    cal_done = 1'b1;
    for (int i = 0; i < 12; i++) begin
      logic [54:0] v;
      v = VEC[i];
      run_pair(v[54:43], v[42:31], v[30], v[29], v[28:27], v[26:24], v[23:12], v[11:0],
               v[30], v[29], tag_of(v[28:27], v[26:24]));
    end
    // R9: select changes after capture; B keeps the captured format
    while (clk_out !== 1'b1) @(negedge clk);
    a_data = 12'h800; b_data = 12'h800; a_ovr = 1'b0; b_ovr = 1'b0; fmt_pin = 2'b00; fmt_ovr = 3'b100;
    @(negedge clk);
    chk(dout, 12'h800, "R9 A offset");
    fmt_ovr = 3'b010;
    @(negedge clk);
    chk(dout, 12'h800, "R9 B keeps captured offset format");
    @(negedge clk);
    chk(dout, 12'hC00, "R9 next capture uses new Gray format");
    // reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    cal_done = 1'b0;
    @(negedge clk);
    chk({11'd0, clk_out}, 12'd0, "R7 clk_out held low in second reset");
    chk(dout, 12'h000, "R7 dout cleared in second reset");
    chk({11'd0, or_out}, 12'd1, "R8 or_out high in second reset");
    @(negedge clk);
    rst_n = 1'b1;
    run_pair(12'h001, 12'h002, 1'b0, 1'b0, 2'b01, 3'b000, 12'h801, 12'h802, 1'b1, 1'b1, "R8 R4 after re-reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule